// File: doc/BRIEF.md
# Matrix Keypad Event Serializer with Ghost Rejection

This block sits behind a matrix keypad scanner. Each time the scanner settles it offers one snapshot: up to eight slots, each with a valid bit, a row number and a column number. The block compares that snapshot with the key set it accepted last time and turns the difference into a serial stream of events on a valid/ready output. Every event carries a scan code and a press/release flag. Release events for keys that have gone away come first, then a press event for every key in the snapshot, then a single sync beat that closes the snapshot.

Two configuration inputs shape the result. With ghost rejection on, a snapshot of three or more keys in which some key shares its row with one other key and its column with another is thrown away whole: no events, no change to the stored set. With the modifier bank on, a key whose raw scan code equals the `fn_code` input is swallowed, and every other key of that snapshot has its code moved into a second bank, one bank being rows times columns codes wide. Slots are assumed to hold distinct matrix positions.

Top module: `keypad_event_gen`

## Requirements
- R1: The raw scan code of a key is its row shifted left by the column width (3 bits with the defaults) ORed with its column; the bank bit, bit 7 with the defaults, is zero when no modifier applies.
- R2: Every stored key whose banked code is absent from an accepted snapshot yields one release event (press flag 0, sync 0) carrying the stored code, in stored slot order.
- R3: Every reported key of an accepted snapshot yields one press event (press flag 1) carrying its banked code, in ascending slot order, and the snapshot then becomes the stored set.
- R4: Within one accepted snapshot all release events precede all press events, and exactly one sync beat (sync 1, press 0, code 0) follows the last of them.
- R5: Ghost rejection is applied only when `ghost_en` is 1 and at least three reported keys are present; a set where row pairs and column pairs involve no common key is not a ghost.
- R6: A ghosted snapshot is consumed but produces no events and leaves the stored set unchanged.
- R7: With `fn_en` 1 and a slot holding code `fn_code`, that key is not reported and every other code of the snapshot is raised by ROWS*COLS (128 with the defaults); with `fn_en` 0 that code is an ordinary key.
- R8: An empty snapshot releases every stored key, emits the sync beat and leaves the stored set empty.
- R9: `snap_ready` is 0 while events of a snapshot remain; while `ev_valid` is 1 and `ev_ready` is 0 the event outputs hold still.
- R10: After reset the stored set is empty, `ev_valid` is 0 and `snap_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ghost_en | input | 1 | Enables ghost rejection |
| fn_en | input | 1 | Enables modifier bank handling |
| fn_code | input | 7 | Raw scan code of the modifier key |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot taken this cycle if valid |
| snap_key_vld | input | 8 | Per-slot key present |
| snap_rows | input | 32 | Per-slot row, 4 bits each, slot 0 lowest |
| snap_cols | input | 24 | Per-slot column, 3 bits each, slot 0 lowest |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Event taken this cycle if valid |
| ev_code | output | 8 | Banked scan code of the event |
| ev_press | output | 1 | 1 for press, 0 for release or sync |
| ev_sync | output | 1 | End-of-snapshot beat |

## Verification
Snapshots are swept over a 4x4 corner of the matrix with holes in the slot list, so ghost triangles, disjoint row and column pairs, repeated sets and modifier presence all occur often; directed cases separate a true triangle from two unrelated pairs, ghost rejection on from off, and the modifier key enabled from disabled. A rejected snapshot is followed by a plain one, whose release list shows whether the stored set moved. Output back-pressure is toggled throughout, which tells apart event ordering faults from faults in holding a stalled beat.

// File: rtl/keypad_event_gen.sv
module keypad_event_gen #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int SLOTS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int KW = RW + CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ghost_en,
  input  logic              fn_en,
  input  logic [KW-1:0]     fn_code,
  input  logic              snap_valid,
  output logic              snap_ready,
  input  logic [SLOTS-1:0]  snap_key_vld,
  input  logic [SLOTS*RW-1:0] snap_rows,
  input  logic [SLOTS*CW-1:0] snap_cols,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [KW:0]       ev_code,
  output logic              ev_press,
  output logic              ev_sync
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [KW:0] BANK = (KW+1)'(ROWS * COLS);
  localparam logic [SLOTS-1:0] ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_REL, S_PRS, S_SYN} st_t;
  st_t st;

  logic [KW-1:0]    raw [SLOTS];
  logic [KW:0]      banked [SLOTS];
  logic [KW:0]      cur_code [SLOTS];
  logic [KW:0]      nxt_code [SLOTS];
  logic [SLOTS-1:0] keep, rel_calc, rel_m, prs_m, cur_keep, nxt_keep;
  logic             fn_hit, ghost;
  logic [IW-1:0]    rel_idx, prs_idx;

  always_comb begin
    fn_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      raw[i]  = {snap_rows[i*RW +: RW], snap_cols[i*CW +: CW]};
      keep[i] = snap_key_vld[i] && !(fn_en && raw[i] == fn_code);
      if (snap_key_vld[i] && fn_en && raw[i] == fn_code) fn_hit = 1'b1;
    end
    for (int i = 0; i < SLOTS; i++)
      banked[i] = {1'b0, raw[i]} + (fn_hit ? BANK : '0);
  end

  always_comb begin
    logic rm, cm;
    ghost = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      rm = 1'b0;
      cm = 1'b0;
      for (int j = 0; j < SLOTS; j++)
        if (j != k && keep[j]) begin
          if (raw[j][KW-1:CW] == raw[k][KW-1:CW]) rm = 1'b1;
          if (raw[j][CW-1:0] == raw[k][CW-1:0]) cm = 1'b1;
        end
      if (keep[k] && rm && cm) ghost = 1'b1;
    end
    ghost = ghost && ghost_en && ($countones(keep) >= 3);
  end

  always_comb begin
    logic hit;
    for (int i = 0; i < SLOTS; i++) begin
      hit = 1'b0;
      for (int j = 0; j < SLOTS; j++)
        if (keep[j] && banked[j] == cur_code[i]) hit = 1'b1;
      rel_calc[i] = cur_keep[i] && !hit;
    end
  end

  always_comb begin
    rel_idx = '0;
    prs_idx = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (rel_m[i]) rel_idx = IW'(i);
      if (prs_m[i]) prs_idx = IW'(i);
    end
  end

  assign snap_ready = (st == S_IDLE);
  assign ev_valid   = (st != S_IDLE);
  assign ev_press   = (st == S_PRS);
  assign ev_sync    = (st == S_SYN);
  assign ev_code    = (st == S_REL) ? cur_code[rel_idx] :
                      (st == S_PRS) ? nxt_code[prs_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_keep <= '0;
      nxt_keep <= '0;
      rel_m    <= '0;
      prs_m    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        cur_code[i] <= '0;
        nxt_code[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (snap_valid && !ghost) begin
          for (int i = 0; i < SLOTS; i++) nxt_code[i] <= banked[i];
          nxt_keep <= keep;
          prs_m    <= keep;
          rel_m    <= rel_calc;
          st <= (rel_calc != '0) ? S_REL : (keep != '0) ? S_PRS : S_SYN;
        end
        S_REL: if (ev_ready) begin
          rel_m[rel_idx] <= 1'b0;
          if ((rel_m & ~(ONE << rel_idx)) == '0)
            st <= (prs_m != '0) ? S_PRS : S_SYN;
        end
        S_PRS: if (ev_ready) begin
          prs_m[prs_idx] <= 1'b0;
          if ((prs_m & ~(ONE << prs_idx)) == '0) st <= S_SYN;
        end
        S_SYN: if (ev_ready) begin
          for (int i = 0; i < SLOTS; i++) cur_code[i] <= nxt_code[i];
          cur_keep <= nxt_keep;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_valid && !ev_ready) |-> ev_valid && $stable(ev_code) && $stable(ev_press) && $stable(ev_sync));
  // R4
  press_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_press) |=> ev_valid && (ev_press || ev_sync));
  // R4
  sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_sync) |=> snap_ready);
  // R6
  ghost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && snap_ready && ghost) |=> $stable(cur_keep) && !ev_valid);
  // R2
  rel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_press && !ev_sync) |-> cur_keep != '0);
endmodule

// File: tb/test_keypad_event_gen.sv
module test_keypad_event_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ghost_en = 1'b0, fn_en = 1'b0;
  logic [6:0] fn_code = '0;
  logic snap_valid = 1'b0, snap_ready;
  logic [7:0] snap_key_vld = '0;
  logic [31:0] snap_rows = '0;
  logic [23:0] snap_cols = '0;
  logic ev_valid, ev_ready = 1'b0, ev_press, ev_sync;
  logic [7:0] ev_code;

  keypad_event_gen i_keypad_event_gen (
    .clk(clk), .rst_n(rst_n), .ghost_en(ghost_en), .fn_en(fn_en), .fn_code(fn_code),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_key_vld(snap_key_vld),
    .snap_rows(snap_rows), .snap_cols(snap_cols), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .ev_press(ev_press), .ev_sync(ev_sync));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int s_vld[8], s_row[8], s_col[8];
  int cur_list[8];
  int cur_n = 0;
  int exp_code[17], exp_kind[17];
  int exp_n;
  bit [31:0] lf = 32'h1ACE_B00C;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_lf();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  task automatic clear_slots();
    for (int i = 0; i < 8; i++) begin s_vld[i] = 0; s_row[i] = 0; s_col[i] = 0; end
  endtask

  task automatic put(input int slot, input int r, input int c);
    s_vld[slot] = 1; s_row[slot] = r; s_col[slot] = c;
  endtask

  task automatic apply(input bit g_en, input bit f_en, input int f_code);
    int raw[8], nc[8];
    bit keep[8];
    bit fnp, gh, rm, cm, found;
    int n, got, prev_code, prev_kind;
    bit prev_hold, done;
    fnp = 0; n = 0; gh = 0; exp_n = 0;
    for (int i = 0; i < 8; i++) begin
      raw[i] = s_row[i] * 8 + s_col[i];   // R1: row shifted by 3, ORed with column
      if (s_vld[i] != 0 && f_en && raw[i] == f_code) fnp = 1;
    end
    for (int i = 0; i < 8; i++) begin
      keep[i] = (s_vld[i] != 0) && !(f_en && raw[i] == f_code);
      if (keep[i]) n++;
      nc[i] = raw[i] + (fnp ? 128 : 0);   // R7 bank offset
    end
    if (g_en && n >= 3)                   // R5
      for (int k = 0; k < 8; k++) begin
        rm = 0; cm = 0;
        for (int j = 0; j < 8; j++)
          if (j != k && keep[j]) begin
            if (s_row[j] == s_row[k]) rm = 1;
            if (s_col[j] == s_col[k]) cm = 1;
          end
        if (keep[k] && rm && cm) gh = 1;
      end
    if (!gh) begin
      for (int i = 0; i < cur_n; i++) begin
        found = 0;
        for (int j = 0; j < 8; j++) if (keep[j] && nc[j] == cur_list[i]) found = 1;
        if (!found) begin exp_code[exp_n] = cur_list[i]; exp_kind[exp_n] = 0; exp_n++; end
      end
      for (int i = 0; i < 8; i++)
        if (keep[i]) begin exp_code[exp_n] = nc[i]; exp_kind[exp_n] = 1; exp_n++; end
      exp_code[exp_n] = 0; exp_kind[exp_n] = 2; exp_n++;
    end

    @(negedge clk);
    chk(snap_ready == 1'b1, "R9 ready when idle", int'(snap_ready), 1);
    ghost_en = g_en; fn_en = f_en; fn_code = 7'(f_code);
    for (int i = 0; i < 8; i++) begin
      snap_key_vld[i] = (s_vld[i] != 0);
      snap_rows[i*4 +: 4] = 4'(s_row[i]);
      snap_cols[i*3 +: 3] = 3'(s_col[i]);
    end
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;

    if (gh) begin
      for (int t = 0; t < 3; t++) begin
        chk(ev_valid == 1'b0, "R6 ghost gives no event", int'(ev_valid), 0);
        @(negedge clk);
      end
      return;
    end

    got = 0; done = 0; prev_hold = 0; prev_code = 0; prev_kind = 0;
    for (int t = 0; t < 200 && !done; t++) begin
      step_lf();
      ev_ready = lf[0] | lf[1];
      if (ev_valid) begin
        chk(snap_ready == 1'b0, "R9 busy blocks snapshot", int'(snap_ready), 0);
        if (prev_hold) begin
          chk(int'(ev_code) == prev_code, "R9 stalled code holds", int'(ev_code), prev_code);
          chk(int'({ev_sync, ev_press}) == prev_kind, "R9 stalled kind holds", int'({ev_sync, ev_press}), prev_kind);
        end
        prev_hold = !ev_ready;
        prev_code = int'(ev_code);
        prev_kind = int'({ev_sync, ev_press});
        if (ev_ready) begin
          if (got < exp_n) begin
            if (exp_kind[got] == 0)
              chk(!ev_press && !ev_sync && int'(ev_code) == exp_code[got], "R2 release event", int'(ev_code), exp_code[got]);
            else if (exp_kind[got] == 1)
              chk(ev_press && !ev_sync && int'(ev_code) == exp_code[got], "R3 press event (R1 R7 code)", int'(ev_code), exp_code[got]);
            else
              chk(ev_sync && !ev_press && ev_code == 8'd0, "R4 sync beat", int'({ev_sync, ev_press}), 2);
          end
          got++;
          if (ev_sync) done = 1;
        end
      end
      @(negedge clk);
    end
    ev_ready = 1'b0;
    chk(got == exp_n, "R4 event count", got, exp_n);
    cur_n = 0;
    for (int i = 0; i < 8; i++) if (keep[i]) begin cur_list[cur_n] = nc[i]; cur_n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", total, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ev_valid == 1'b0, "R10 ev_valid after reset", int'(ev_valid), 0);
    chk(snap_ready == 1'b1, "R10 snap_ready after reset", int'(snap_ready), 1);
    rst_n = 1'b1;

    clear_slots(); apply(1, 0, 0);                       // R8 empty with empty store: sync only
    clear_slots(); put(0, 1, 2); put(3, 3, 4); apply(1, 0, 0);   // R3 press 10, 28
    clear_slots(); put(1, 3, 4); apply(1, 0, 0);         // R2 release 10
    clear_slots(); put(0, 0, 0); put(2, 0, 1); put(5, 1, 0); apply(1, 0, 0); // R6 ghost
    clear_slots(); put(4, 3, 4); apply(1, 0, 0);         // R6 store unchanged: press only
    clear_slots(); put(0, 0, 0); put(2, 0, 1); put(5, 1, 0); apply(0, 0, 0); // R5 filter off
    clear_slots(); put(0, 0, 0); put(1, 0, 1); put(2, 5, 5); put(3, 6, 5); apply(1, 0, 0); // R5 no triangle
    clear_slots(); put(6, 2, 5); put(7, 1, 1); apply(1, 1, 21); // R7 modifier swallowed, bank 137
    clear_slots(); put(6, 2, 5); put(7, 1, 1); apply(1, 0, 21); // R7 modifier off, ordinary key
    clear_slots(); put(0, 2, 5); apply(1, 1, 21);         // R7 modifier alone
    clear_slots(); apply(1, 1, 21);                       // R8 empty
    clear_slots(); put(0, 4, 4); put(1, 4, 5); apply(1, 0, 0);
    clear_slots(); apply(0, 0, 0);                        // R8 release all

    for (int s = 0; s < 400; s++) begin
      bit clash;
      clear_slots();
      for (int i = 0; i < 8; i++) begin
        step_lf();
        if (lf[2:0] < 3'd3) begin
          clash = 0;
          for (int j = 0; j < i; j++)
            if (s_vld[j] != 0 && s_row[j] == int'(lf[5:4]) && s_col[j] == int'(lf[7:6])) clash = 1;
          if (!clash) put(i, int'(lf[5:4]), int'(lf[7:6]));
        end
      end
      step_lf();
      apply(lf[0], lf[1], 17);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule